// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting timer channel. Counting advances only on clock cycles where the counting enable `cnt_en` is high. A gate input qualifies or retriggers counting, depending on the mode. One output pin carries the waveform that the selected mode produces. Writing a mode stops the channel and sets the output to that mode's idle level. A load strobe then supplies a 16-bit initial value N, and a load value of zero means 65536.

There are six modes, numbered 0 to 5:

| Mode | Name | Output behaviour |
|------|------|------------------|
| 0 | terminal-count interrupt | Output goes high after N counts and stays high. |
| 1 | gate-retriggered one-shot | Output is low for N counts after each rising edge of the gate. |
| 2 | rate generator | Output drops low for one count in every N, and the counter reloads itself. |
| 3 | square wave | Counter steps by two; output is high for (N+1)/2 counts and low for the rest of each period. |
| 4 | software strobe | One low pulse of one count, N counts after the load. |
| 5 | hardware strobe | Same single pulse as mode 4, but started by a rising edge of the gate. |

The running count value is driven continuously on `count`, so a surrounding register interface can latch it. Bus decoding, byte sequencing and BCD counting belong to that surrounding logic.

Top module: `pit_channel`

## Requirements
- R1: After a synchronous reset the channel is in mode 3 with an initial value of 65536, idle, `out` high and `count` 0; a rising gate edge then starts a 65536-count square wave.
- R2: A load value of 0 is taken as 65536; the counter starts at 65536 (`count` shows 0) and the next count shows 65535.
- R3: The counter and the output change on counting events only on cycles with `cnt_en` high; the count never moves while `cnt_en` is low.
- R4: Mode 0 (`mode_sel` = 0): a load drives `out` low on the next clock. The counter starts at N on the next counting cycle, and `out` rises when the count reaches 0. It then stays high and counting stops.
- R5: Mode 1: a rising gate edge arms a start. At the next counting cycle the count restarts at N and `out` goes low. `out` returns high when the count reaches 0. A later rising edge retriggers the count, even in mid-count.
- R6: Mode 2: the count runs N down to 1 and then reloads N. `out` is low exactly while the count equals 1, so there is one low count per period of N.
- R7: Mode 3: the counter decrements by 2. The high phase lasts (N+1)/2 counts (count starts at N rounded up to even) and the low phase lasts N/2 counts (count starts at N rounded down to even, at least 2). `out` toggles when the count reaches 2 and the next phase is reloaded.
- R8: Modes 4 and 5: `out` is high while counting and falls when the count reaches 0 after N counts. It rises again one count later and counting stops. In mode 5 the count is started and restarted by rising gate edges (modes 1, 2, 3 and 5 retrigger on a rising gate).
- R9: With the gate low, counting is frozen in modes 0, 2, 3 and 4. In modes 2 and 3 a low gate also holds `out` high.
- R10: In modes 0 and 4 a new load restarts the count with the new value at the next counting cycle. In a running mode 2 or 3 a new value is used only at the next reload.
- R11: A mode write (`mode_wr`) overrides a load or gate edge in the same cycle. It stops counting and sets `out` low for mode 0 and high for the other modes. Codes 6 and 7 select modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting-clock enable; one count per high cycle |
| gate | input | 1 | Gate: enables counting or retriggers, per mode |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel | input | 3 | Mode code written by `mode_wr` |
| load | input | 1 | Load strobe for the initial value |
| load_val | input | CW | Initial value; 0 means 2^CW |
| out | output | 1 | Registered channel output |
| count | output | CW | Current counter value (low CW bits) |

## Verification
The hardest situations to reach are the interactions between three events: a start waiting for its counting cycle, a gate edge or a fresh load arriving meanwhile, and a mode 3 phase reload that picks up the new value. These only occur when the enable is sparse and irregular. The stimulus therefore runs modes 2 and 3 under a pseudo-random enable and a one-in-three enable. During those runs it reloads mid-period, drops the gate mid-phase and retriggers. A behavioural reference model follows every cycle and compares `out` and `count`.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } pit_mode_e;

  function automatic pit_mode_e decode_mode(input logic [2:0] code);
    // codes 6 and 7 alias onto the rate and square modes
    if (code[2] && code[1]) return pit_mode_e'({1'b0, code[1:0]});
    return pit_mode_e'(code);
  endfunction
endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic [2:0]    mode_sel,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          gate_rise,
  input  logic          tick,
  input  logic          running,
  output pit_mode_e     mode,
  output pit_mode_e     mode_nxt,
  output logic [CW:0]   init,
  output logic          start,
  output logic          load_low
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

  logic pend;
  logic retrig;
  logic restart_on_load;

  assign mode_nxt = decode_mode(mode_sel);
  assign retrig   = (mode == M_ONESHOT) || (mode == M_RATE) ||
                    (mode == M_SQUARE)  || (mode == M_HWSTROBE);
  assign restart_on_load = (mode == M_TERM) || (mode == M_SWSTROBE) ||
                           (((mode == M_RATE) || (mode == M_SQUARE)) && !running);
  assign start    = pend & tick;
  assign load_low = load & ~mode_wr & (mode == M_TERM);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= M_SQUARE;
      init <= FULL;
      pend <= 1'b0;
    end else if (mode_wr) begin
      mode <= mode_nxt;
      pend <= 1'b0;
    end else begin
      if (tick) pend <= 1'b0;
      if (load) begin
        init <= (load_val == '0) ? FULL : {1'b0, load_val};
        if (restart_on_load) pend <= 1'b1;
      end
      if (gate_rise && retrig) pend <= 1'b1;
    end
  end

  // R2: the stored initial value is never zero
  p_init_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    init != '0);
endmodule

// File: rtl/pit_wave.sv
module pit_wave
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          gate,
  input  logic          mode_wr,
  input  pit_mode_e     mode,
  input  pit_mode_e     mode_nxt,
  input  logic [CW:0]   init,
  input  logic          start,
  input  logic          load_low,
  output logic          out,
  output logic          running,
  output logic [CW-1:0] count
);
  localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};
  localparam logic [CW:0] TWO = {{(CW-1){1'b0}}, 2'b10};

  logic [CW:0] cnt;
  logic [CW:0] hi_load;
  logic [CW:0] lo_even;
  logic [CW:0] lo_load;
  logic [CW:0] rate_nxt;
  logic        is_sq_rate;
  logic        frozen;

  assign hi_load    = (init + ONE) & ~ONE;
  assign lo_even    = init & ~ONE;
  assign lo_load    = (lo_even == '0) ? TWO : lo_even;
  assign rate_nxt   = (cnt == ONE) ? init : (cnt - ONE);
  assign is_sq_rate = (mode == M_RATE) || (mode == M_SQUARE);
  assign frozen     = !gate && (mode != M_ONESHOT) && (mode != M_HWSTROBE);
  assign count      = cnt[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      out     <= 1'b1;
      running <= 1'b0;
    end else if (mode_wr) begin
      running <= 1'b0;
      out     <= (mode_nxt != M_TERM);
    end else begin
      if (tick) begin
        if (start) begin
          running <= 1'b1;
          unique case (mode)
            M_TERM, M_ONESHOT: begin cnt <= init;    out <= 1'b0; end
            M_RATE:            begin cnt <= init;    out <= (init != ONE); end
            M_SQUARE:          begin cnt <= hi_load; out <= 1'b1; end
            default:           begin cnt <= init;    out <= 1'b1; end
          endcase
        end else if (running && !frozen) begin
          unique case (mode)
            M_TERM, M_ONESHOT: begin
              cnt <= cnt - ONE;
              if (cnt == ONE) begin
                out     <= 1'b1;
                running <= 1'b0;
              end
            end
            M_RATE: begin
              cnt <= rate_nxt;
              out <= (rate_nxt != ONE);
            end
            M_SQUARE: begin
              if (cnt == TWO) begin
                out <= ~out;
                cnt <= out ? lo_load : hi_load;
              end else begin
                cnt <= cnt - TWO;
              end
            end
            default: begin
              if (cnt == '0) begin
                out     <= 1'b1;
                running <= 1'b0;
              end else begin
                cnt <= cnt - ONE;
                if (cnt == ONE) out <= 1'b0;
              end
            end
          endcase
        end
      end
      if (is_sq_rate && !gate) out <= 1'b1;
      if (load_low) out <= 1'b0;
    end
  end

  // R3: no counter movement without the counting enable
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R9: a low gate holds the output high in rate and square modes
  p_gate_high_r9: assert property (@(posedge clk) disable iff (rst)
    (is_sq_rate && !gate && !mode_wr) |=> out);
  // R4: once high in mode 0 the output stays high until a new load or mode write
  p_term_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_TERM) && out && !mode_wr && !load_low) |=> out);
  // R6: a running rate generator never shows a zero count
  p_rate_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    (running && (mode == M_RATE)) |-> (cnt != '0));
  // R7: a running square wave counter is always even
  p_square_even_r7: assert property (@(posedge clk) disable iff (rst)
    (running && (mode == M_SQUARE)) |-> !cnt[0]);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          gate,
  input  logic          mode_wr,
  input  logic [2:0]    mode_sel,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          out,
  output logic [CW-1:0] count
);
  logic        gate_rise;
  logic        running;
  logic        start;
  logic        load_low;
  logic [CW:0] init;
  pit_mode_e   mode;
  pit_mode_e   mode_nxt;

  pit_gate_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  pit_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (mode_wr),
    .mode_sel  (mode_sel),
    .load      (load),
    .load_val  (load_val),
    .gate_rise (gate_rise),
    .tick      (cnt_en),
    .running   (running),
    .mode      (mode),
    .mode_nxt  (mode_nxt),
    .init      (init),
    .start     (start),
    .load_low  (load_low)
  );

  pit_wave #(.CW(CW)) u_wave (
    .clk      (clk),
    .rst      (rst),
    .tick     (cnt_en),
    .gate     (gate),
    .mode_wr  (mode_wr),
    .mode     (mode),
    .mode_nxt (mode_nxt),
    .init     (init),
    .start    (start),
    .load_low (load_low),
    .out      (out),
    .running  (running),
    .count    (count)
  );
endmodule

// File: tb/tb_pit_channel.sv
`timescale 1ns/1ps
module tb_pit_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        load = 1'b0;
  logic [15:0] load_val = 16'd0;
  logic        out;
  logic [15:0] count;

  pit_channel #(.CW(16)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate),
    .mode_wr(mode_wr), .mode_sel(mode_sel), .load(load),
    .load_val(load_val), .out(out), .count(count)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";
  int en_pat = 0;
  int phase = 0;
  logic [15:0] lf = 16'hACE1;

  // behavioural reference state
  int m_mode = 3, m_init = 65536, m_cnt = 0, m_out = 1, m_run = 0, m_pend = 0, m_gq = 0;

  function automatic int even_up(int v);   return (v + 1) & ~1; endfunction
  function automatic int low_phase(int v); return ((v & ~1) == 0) ? 2 : (v & ~1); endfunction

  always @(posedge clk) begin
    int rise, old_run, old_pend, old_init, frz, nx;
    if (rst) begin
      m_mode = 3; m_init = 65536; m_cnt = 0; m_out = 1; m_run = 0; m_pend = 0; m_gq = 0;
    end else begin
      rise = (gate && !m_gq) ? 1 : 0;
      m_gq = gate;
      if (mode_wr) begin
        m_mode = (mode_sel >= 6) ? int'(mode_sel) - 4 : int'(mode_sel);
        m_run = 0; m_pend = 0; m_out = (m_mode != 0) ? 1 : 0;
      end else begin
        old_run = m_run; old_pend = m_pend; old_init = m_init;
        if (cnt_en) begin
          m_pend = 0;
          if (old_pend) begin
            m_run = 1;
            if (m_mode == 3) begin m_cnt = even_up(old_init); m_out = 1; end
            else begin
              m_cnt = old_init;
              if (m_mode <= 1) m_out = 0;
              else if (m_mode == 2) m_out = (old_init != 1) ? 1 : 0;
              else m_out = 1;
            end
          end else if (m_run) begin
            frz = (!gate && m_mode != 1 && m_mode != 5) ? 1 : 0;
            if (!frz) begin
              if (m_mode <= 1) begin
                if (m_cnt == 1) begin m_out = 1; m_run = 0; end
                m_cnt = m_cnt - 1;
              end else if (m_mode == 2) begin
                nx = (m_cnt == 1) ? old_init : m_cnt - 1;
                m_cnt = nx; m_out = (nx != 1) ? 1 : 0;
              end else if (m_mode == 3) begin
                if (m_cnt == 2) begin
                  m_cnt = m_out ? low_phase(old_init) : even_up(old_init);
                  m_out = 1 - m_out;
                end else m_cnt = m_cnt - 2;
              end else begin
                if (m_cnt == 0) begin m_out = 1; m_run = 0; end
                else begin
                  if (m_cnt == 1) m_out = 0;
                  m_cnt = m_cnt - 1;
                end
              end
            end
          end
        end
        if ((m_mode == 2 || m_mode == 3) && !gate) m_out = 1;
        if (load) begin
          m_init = (load_val == 0) ? 65536 : int'(load_val);
          if (m_mode == 0) m_out = 0;
          if (m_mode == 0 || m_mode == 4 || ((m_mode == 2 || m_mode == 3) && !old_run)) m_pend = 1;
        end
        if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) m_pend = 1;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (cmp_on) begin
      check(cur_req, "out", int'(out), m_out);
      check(cur_req, "count", int'(count), m_cnt & 16'hFFFF);
    end
    load = 1'b0;
    mode_wr = 1'b0;
    phase++;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    case (en_pat)
      0: cnt_en = 1'b1;
      1: cnt_en = (phase % 3 == 0);
      default: cnt_en = lf[0] ^ lf[5];
    endcase
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_mode(int m);
    mode_wr = 1'b1; mode_sel = 3'(m); cyc();
  endtask

  task automatic do_load(int v);
    load = 1'b1; load_val = 16'(v); cyc();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    cyc();
    check("R1", "reset out", int'(out), 1);
    check("R1", "reset count", int'(count), 0);
    cmp_on = 1;
    // R1: default mode 3 with 65536 started by a gate rise
    cur_req = "R1"; en_pat = 0; gate = 1'b1; run(12);
    // R11 / R4: mode 0
    cur_req = "R11"; set_mode(0); run(2);
    cur_req = "R4"; do_load(5); run(12);
    // R9: freeze in mode 0
    cur_req = "R9"; do_load(7); run(3); gate = 1'b0; run(5); gate = 1'b1; run(10);
    // R2: zero load
    cur_req = "R2"; do_load(0); run(20);
    // R5: one-shot with retrigger
    cur_req = "R5"; set_mode(1); gate = 1'b0; do_load(4); gate = 1'b1; run(3);
    gate = 1'b0; cyc(); gate = 1'b1; run(10);
    // R6 / R3: rate generator with sparse enable, reload and gate low
    cur_req = "R6 R3"; set_mode(2); gate = 1'b1; en_pat = 1; do_load(4); run(30);
    cur_req = "R10"; do_load(6); run(40);
    cur_req = "R9"; gate = 1'b0; run(5); gate = 1'b1; run(25);
    // R7: square wave through alias code 7, odd and even N, random enable
    cur_req = "R7 R11"; set_mode(7); en_pat = 2; do_load(5); run(60);
    cur_req = "R7 R10"; do_load(6); run(60);
    cur_req = "R9"; gate = 1'b0; run(4); gate = 1'b1; run(30);
    cur_req = "R7"; en_pat = 0; do_load(1); run(12);
    // R8: software strobe, then reload mid-count
    cur_req = "R8"; set_mode(4); do_load(3); run(10);
    cur_req = "R10"; do_load(5); run(3); do_load(2); run(10);
    cur_req = "R9"; do_load(6); run(2); gate = 1'b0; run(4); gate = 1'b1; run(10);
    // R8: hardware strobe with retrigger
    cur_req = "R8"; set_mode(5); gate = 1'b0; do_load(3); gate = 1'b1; run(2);
    gate = 1'b0; cyc(); gate = 1'b1; run(10);
    // R11: mode write wins over a simultaneous load
    cur_req = "R11"; mode_wr = 1'b1; mode_sel = 3'd6; load = 1'b1; load_val = 16'd9; cyc();
    run(8);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL all requirements: watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule